// File: doc/BRIEF.md
# Condition-Code Add/Subtract Unit

This block is an integer adder/subtractor that returns both a wrapped result and a 2-bit condition code. It handles four operations: unsigned ("logical") add and subtract, and two's-complement ("signed") add and subtract. Each operation encodes the condition code its own way. The logical operations report zero/non-zero together with carry or no-borrow. The signed operations report zero, negative, positive or overflow.

A width select picks 64-bit or 32-bit operation. In 32-bit operation only the low 32 bits of each operand take part, and the upper result bits are forced to zero. An operation is presented with a one-cycle valid strobe. Result, code and valid appear on the registered outputs at the next clock edge. Between strobes the outputs hold their last values.

Top module: `ccau_top`

## Requirements
- R1: Logical add (`in_op` = 2'b00): code bit 0 is 1 when the result is non-zero, and code bit 1 is 1 when the addition carries out of the top bit of the selected width.
- R2: Logical subtract (`in_op` = 2'b01): code bit 0 is 1 when the result is non-zero, and code bit 1 is 1 when no borrow occurred, that is when the first operand is not less than the second as unsigned numbers.
- R3: A logical subtract never returns code 0: an equal-operand subtract gives code 2.
- R4: Signed add (`in_op` = 2'b10): the code is 0 for a zero result, 1 for a negative one, 2 for a positive one, and 3 when both operands share a sign that the result does not have.
- R5: Signed subtract (`in_op` = 2'b11) uses the same code values. It overflows (code 3) when the operand signs differ and the result sign differs from the first operand's sign.
- R6: Signed overflow wins over every other code, including when the wrapped result is zero.
- R7: With `in_wide` = 1 the unit works on 64 bits, and with `in_wide` = 0 on 32 bits. The result wraps modulo 2^width, and operand bits above the selected width have no effect on the result or the code.
- R8: In 32-bit operation, result bits 63:32 are zero, and carry, borrow and overflow are judged at bit 31.
- R9: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1. The result and code computed from that cycle's inputs appear alongside it.
- R10: In a cycle without a strobe, `out_res` and `out_cc` keep their previous values.
- R11: A synchronous reset clears `out_valid`, `out_res` and `out_cc` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | 00 logical add, 01 logical subtract, 10 signed add, 11 signed subtract |
| in_wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_res | output | 64 | Wrapped result |
| out_cc | output | 2 | Condition code |

## Verification
The bench aims at the code boundaries where a careless design goes wrong.

- Logical add that wraps exactly to zero: the right answer is code 2. A design that ignores the carry would return 0.
- Equal-operand and zero-minus-one subtracts: these expose a borrow sense that is inverted or taken from the wrong comparison.
- Signed additions whose wrapped sum is zero: a design that lets the zero test beat overflow would return 0 instead of 3.
- Minimum-minus-one and maximum-plus-one in both widths.
- 32-bit operations with garbage in the upper operand halves: these reveal carry or overflow taken from bit 63, or upper result bits leaking through.
- Idle cycles and a mid-run reset: these catch outputs that drift without a strobe or that survive reset.

// File: rtl/ccau_pkg.sv
package ccau_pkg;

    typedef enum logic [1:0] {
        OP_ADD_LOG = 2'b00,
        OP_SUB_LOG = 2'b01,
        OP_ADD_SGN = 2'b10,
        OP_SUB_SGN = 2'b11
    } ccau_op_e;

    typedef logic [1:0] ccau_cc_t;

    function automatic logic op_is_sub(ccau_op_e op);
        return op[0];
    endfunction

    function automatic logic op_is_signed(ccau_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/ccau_addsub.sv
module ccau_addsub #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff = b ^ {W{sub}};
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = full[W-1:0];
        cout  = full[W];
    end
endmodule

// File: rtl/ccau_ccgen.sv
module ccau_ccgen
    import ccau_pkg::*;
(
    input  ccau_op_e op,
    input  logic     zero,
    input  logic     carry,
    input  logic     sign_a,
    input  logic     sign_b,
    input  logic     sign_r,
    output ccau_cc_t cc
);
    logic ovf;

    always_comb begin
        if (op_is_sub(op))
            ovf = (sign_a != sign_b) && (sign_r != sign_a);
        else
            ovf = (sign_a == sign_b) && (sign_r != sign_a);

        if (!op_is_signed(op))
            cc = {carry, !zero};
        else if (ovf)
            cc = 2'd3;
        else if (zero)
            cc = 2'd0;
        else if (sign_r)
            cc = 2'd1;
        else
            cc = 2'd2;
    end
endmodule

// File: rtl/ccau_top.sv
module ccau_top
    import ccau_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_res,
    output logic [1:0]        out_cc
);
    localparam int PAD_W = DATA_W - NARROW_W;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
        ccau_cc_t          cc;
    } state_t;

    state_t   st_d, st_q;
    ccau_op_e op;

    logic [DATA_W-1:0]   sum_w;
    logic                cout_w;
    logic [NARROW_W-1:0] sum_n;
    logic                cout_n;

    logic     sel_zero, sel_carry, sel_sa, sel_sb, sel_sr;
    ccau_cc_t cc_new;

    assign op = ccau_op_e'(in_op);

    ccau_addsub #(.W(DATA_W)) u_wide (
        .a    (in_a),
        .b    (in_b),
        .sub  (op_is_sub(op)),
        .sum  (sum_w),
        .cout (cout_w)
    );

    ccau_addsub #(.W(NARROW_W)) u_narrow (
        .a    (in_a[NARROW_W-1:0]),
        .b    (in_b[NARROW_W-1:0]),
        .sub  (op_is_sub(op)),
        .sum  (sum_n),
        .cout (cout_n)
    );

    always_comb begin
        if (in_wide) begin
            sel_zero  = (sum_w == '0);
            sel_carry = cout_w;
            sel_sa    = in_a[DATA_W-1];
            sel_sb    = in_b[DATA_W-1];
            sel_sr    = sum_w[DATA_W-1];
        end else begin
            sel_zero  = (sum_n == '0);
            sel_carry = cout_n;
            sel_sa    = in_a[NARROW_W-1];
            sel_sb    = in_b[NARROW_W-1];
            sel_sr    = sum_n[NARROW_W-1];
        end
    end

    ccau_ccgen u_cc (
        .op     (op),
        .zero   (sel_zero),
        .carry  (sel_carry),
        .sign_a (sel_sa),
        .sign_b (sel_sb),
        .sign_r (sel_sr),
        .cc     (cc_new)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res = in_wide ? sum_w : {{PAD_W{1'b0}}, sum_n};
            st_d.cc  = cc_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_res   = st_q.res;
    assign out_cc    = st_q.cc;

    a_r9_valid_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(in_wide)) |-> (out_res[DATA_W-1:NARROW_W] == '0));

    a_r3_sublog_no_code0: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_op) == 2'b01) |-> (out_cc != 2'd0));

    a_r1_logical_zero_bit: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(in_op[1])) |-> (out_cc[0] == (out_res != '0)));

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> ($stable(out_res) && $stable(out_cc)));

endmodule

// File: tb/sim_ccau_top.sv
module sim_ccau_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic        in_wide = 1'b1;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_res;
    logic [1:0]  out_cc;

    int n_checks = 0;
    int n_fail   = 0;

    logic        exp_valid = 1'b0;
    logic [63:0] exp_res   = '0;
    logic [1:0]  exp_cc    = '0;
    string       exp_tag   = "R11";

    always #10 clk = ~clk;

    ccau_top u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_res(out_res), .out_cc(out_cc)
    );

    function automatic string tag_of(logic [1:0] op, logic wide);
        string t;
        case (op)
            2'b00: t = "R1";
            2'b01: t = "R2/R3";
            2'b10: t = "R4/R6";
            default: t = "R5/R6";
        endcase
        return wide ? {t, "/R7"} : {t, "/R7/R8"};
    endfunction

    task automatic model(input logic [1:0] op, input logic wide,
                         input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic [1:0] cc);
        int n;
        logic [65:0] mask, ua, ub, full;
        logic signed [65:0] sa, sb, ss, smax, smin;
        n    = wide ? 64 : 32;
        mask = (66'd1 << n) - 66'd1;
        ua   = {2'b0, a} & mask;
        ub   = {2'b0, b} & mask;
        sa   = ua[n-1] ? $signed(ua) - $signed(66'd1 << n) : $signed(ua);
        sb   = ub[n-1] ? $signed(ub) - $signed(66'd1 << n) : $signed(ub);
        smax = $signed((66'd1 << (n-1)) - 66'd1);
        smin = -smax - 66'sd1;
        case (op)
            2'b00: begin
                full = ua + ub;
                r = full[63:0] & mask[63:0];
                cc = {full[n], r != 0};
            end
            2'b01: begin
                full = ua - ub;
                r = full[63:0] & mask[63:0];
                cc = {ua >= ub, r != 0};
            end
            default: begin
                ss = (op == 2'b10) ? sa + sb : sa - sb;
                r = ss[63:0] & mask[63:0];
                if (ss > smax || ss < smin) cc = 2'd3;
                else if (ss == 0)           cc = 2'd0;
                else if (ss < 0)            cc = 2'd1;
                else                        cc = 2'd2;
            end
        endcase
    endtask

    always @(posedge clk) begin
        logic [63:0] r;
        logic [1:0]  c;
        if (rst) begin
            exp_valid <= 1'b0;
            exp_res   <= '0;
            exp_cc    <= '0;
            exp_tag   <= "R11";
        end else begin
            exp_valid <= in_valid;
            if (in_valid) begin
                model(in_op, in_wide, in_a, in_b, r, c);
                exp_res <= r;
                exp_cc  <= c;
                exp_tag <= {tag_of(in_op, in_wide), "/R9"};
            end else begin
                exp_tag <= "R10/R9";
            end
        end
    end

    task automatic compare();
        n_checks++;
        if (out_valid !== exp_valid || out_res !== exp_res || out_cc !== exp_cc) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b res=%h cc=%0d, expected valid=%0b res=%h cc=%0d",
                     exp_tag, out_valid, out_res, out_cc, exp_valid, exp_res, exp_cc);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] op, input logic w,
                        input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        compare();
        in_valid = v; in_op = op; in_wide = w; in_a = a; in_b = b;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step(0, 2'b00, 1, 64'd5, 64'd7);   // R11 reset state
        // R1 carry wraps to zero in 64 bits -> code 2
        step(1, 2'b00, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        step(1, 2'b00, 1, 64'd3, 64'd4);
        // R1/R8 narrow carry at bit 31 with garbage upper bits (R7)
        step(1, 2'b00, 0, 64'hABCD_0000_FFFF_FFFF, 64'h1234_0000_0000_0002);
        // R2/R3 equal operands -> code 2, 0-1 -> code 1
        step(1, 2'b01, 1, 64'd77, 64'd77);
        step(1, 2'b01, 1, 64'd0, 64'd1);
        step(1, 2'b01, 0, 64'hFFFF_0000_0000_0000, 64'h0000_0001_0000_0001);
        step(1, 2'b01, 0, 64'h5555_5555_8000_0000, 64'h0000_0000_7FFF_FFFF);
        // R4/R6 overflow with zero sum
        step(1, 2'b10, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000);
        step(1, 2'b10, 1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        step(1, 2'b10, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
        step(1, 2'b10, 1, 64'd5, -64'sd5);
        step(1, 2'b10, 0, 64'd2, 64'hFFFF_FFFF_FFFF_FFFD);
        // R10 idle cycles hold
        step(0, 2'b11, 1, 64'd9, 64'd1);
        step(0, 2'b00, 0, 64'd1, 64'd1);
        // R5 signed subtract boundaries
        step(1, 2'b11, 1, 64'h8000_0000_0000_0000, 64'd1);
        step(1, 2'b11, 0, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        step(1, 2'b11, 0, 64'd4, 64'd4);
        step(1, 2'b11, 1, 64'd3, 64'd10);
        step(1, 2'b11, 1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (i % 7 == 0) rb = ra;
            if (i % 11 == 0) rb = -ra;
            step(($urandom % 4) != 0, 2'($urandom), 1'($urandom), ra, rb);
        end
        // R11 reset mid-run
        step(1, 2'b00, 1, 64'd100, 64'd200);
        @(negedge clk);
        compare();
        rst = 1'b1;
        in_valid = 1'b1;
        step(1, 2'b00, 1, 64'd1, 64'd1);
        @(negedge clk);
        compare();
        rst = 1'b0;
        in_valid = 1'b0;
        step(0, 2'b00, 1, 64'd0, 64'd0);
        step(0, 2'b00, 1, 64'd0, 64'd0);
        finish_run();
    end
endmodule